// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with Normal/Fast Routing

This block collects 32 level-sensitive request lines and turns them into two interrupt outputs for a processor core: a normal interrupt and a fast interrupt. Each request line first passes through a two-flop synchroniser. An enable register turns individual sources on or off. A routing register then sends each enabled source either to the normal output or to the fast output.

Software works through a single-cycle register port. It reads the synchronised raw status, the enabled normal-routed status and the enabled fast-routed status. The usual handler takes the lowest set bit of the normal status, services that source and reads again until the status is zero. No acknowledge is needed: a status bit falls once its request line falls.

A third output, idle wake, tells the core to leave its wait-for-interrupt state. One control bit selects what drives it. When the bit is clear, any raw request wakes the core. When it is set, only enabled requests do.

Top module: `irqc_top`

## Requirements
- R1: While reset is held and after its release, the enable, routing and control registers read as zero, and irq_o, fiq_o and wake_o are low while no request has arrived.
- R2: The raw status register at offset 0x20 shows req_i as sampled two rising clock edges earlier. A bit falls when its request line falls, with no acknowledge.
- R3: The enable register at offset 0x04 is read/write. A bit value of 1 enables that source and 0 disables it. A write replaces the whole word.
- R4: The routing register at offset 0x08 is read/write. Bit value 0 sends the source to the normal output and 1 sends it to the fast output.
- R5: Offset 0x00 reads raw AND enable AND NOT routing. irq_o is high exactly when that value is nonzero.
- R6: Offset 0x10 reads raw AND enable AND routing. fiq_o is high exactly when that value is nonzero.
- R7: When control bit 0 is clear, wake_o is high whenever any raw bit is set. When control bit 0 is set, wake_o is high only when raw AND enable is nonzero.
- R8: The control register at offset 0x0C keeps only bit 0. Bits 31:1 read as zero.
- R9: Writes to the status offsets 0x00, 0x10 and 0x20, and to any unmapped offset, change no register. Unmapped offsets read as zero.
- R10: Writing the enable register with bits 11:0 cleared and all other bits kept disables exactly sources 0 to 11. The other enabled sources still reach the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 32 | Asynchronous level-sensitive request lines, one per source |
| addr_i | input | 8 | Register byte offset |
| we_i | input | 1 | Write strobe, sampled at the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational from register state |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Idle-wake request |

## Verification
Fixed request patterns come first. One pattern has set bits at both ends of the word, read through every status offset, so the AND-NOT normal path and the AND fast path can be told apart. A second pattern is all ones, so that clearing the low twelve enable bits shows whether the cut falls exactly at bit 12. The wake output is driven with everything disabled, once under each control setting, which separates the raw wake path from the enabled-only path. Writes to status and unmapped offsets show whether any stray decode reaches a register. A long stretch of random requests, offsets and writes is then compared on every cycle against a queue-based reference, which catches off-by-one synchroniser latency and routing faults.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_PEND_NRM = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_ENABLE   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_ROUTE    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_CTRL     = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_PEND_FST = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_RAW      = 8'h20;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PEND_NRM,
    SEL_ENABLE,
    SEL_ROUTE,
    SEL_CTRL,
    SEL_PEND_FST,
    SEL_RAW
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_PEND_NRM: decode = SEL_PEND_NRM;
      OFS_ENABLE:   decode = SEL_ENABLE;
      OFS_ROUTE:    decode = SEL_ROUTE;
      OFS_CTRL:     decode = SEL_CTRL;
      OFS_PEND_FST: decode = SEL_PEND_FST;
      OFS_RAW:      decode = SEL_RAW;
      default:      decode = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irqc_core.sv
module irqc_core #(
  parameter int unsigned NSRC = 32
) (
  input  logic [NSRC-1:0] raw_i,
  input  logic [NSRC-1:0] enable_i,
  input  logic [NSRC-1:0] route_i,
  input  logic            wake_sel_i,
  output logic [NSRC-1:0] pend_nrm_o,
  output logic [NSRC-1:0] pend_fst_o,
  output logic            irq_o,
  output logic            fiq_o,
  output logic            wake_o
);
  logic [NSRC-1:0] live;

  assign live       = raw_i & enable_i;
  assign pend_nrm_o = live & ~route_i;
  assign pend_fst_o = live & route_i;
  assign irq_o      = |pend_nrm_o;
  assign fiq_o      = |pend_fst_o;
  // wake_sel set: only enabled sources may wake the core
  assign wake_o     = wake_sel_i ? (|live) : (|raw_i);
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [NSRC-1:0]   wdata_i,
  input  logic [NSRC-1:0]   raw_i,
  input  logic [NSRC-1:0]   pend_nrm_i,
  input  logic [NSRC-1:0]   pend_fst_i,
  output logic [NSRC-1:0]   enable_o,
  output logic [NSRC-1:0]   route_o,
  output logic              wake_sel_o,
  output logic [NSRC-1:0]   rdata_o
);
  reg_sel_e sel;
  assign sel = decode(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_o   <= '0;
      route_o    <= '0;
      wake_sel_o <= 1'b0;
    end else if (we_i) begin
      case (sel)
        SEL_ENABLE: enable_o   <= wdata_i;
        SEL_ROUTE:  route_o    <= wdata_i;
        SEL_CTRL:   wake_sel_o <= wdata_i[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_PEND_NRM: rdata_o = pend_nrm_i;
      SEL_ENABLE:   rdata_o = enable_o;
      SEL_ROUTE:    rdata_o = route_o;
      SEL_CTRL:     rdata_o = {{(NSRC-1){1'b0}}, wake_sel_o};
      SEL_PEND_FST: rdata_o = pend_fst_i;
      SEL_RAW:      rdata_o = raw_i;
      default:      rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC        = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [NSRC-1:0]   wdata_i,
  output logic [NSRC-1:0]   rdata_o,
  output logic              irq_o,
  output logic              fiq_o,
  output logic              wake_o
);
  logic [NSRC-1:0] raw_q;
  logic [NSRC-1:0] enable_q;
  logic [NSRC-1:0] route_q;
  logic            wake_sel_q;
  logic [NSRC-1:0] pend_nrm;
  logic [NSRC-1:0] pend_fst;

  irqc_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (req_i),
    .q_o    (raw_q)
  );

  irqc_regs #(.NSRC(NSRC)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .we_i       (we_i),
    .wdata_i    (wdata_i),
    .raw_i      (raw_q),
    .pend_nrm_i (pend_nrm),
    .pend_fst_i (pend_fst),
    .enable_o   (enable_q),
    .route_o    (route_q),
    .wake_sel_o (wake_sel_q),
    .rdata_o    (rdata_o)
  );

  irqc_core #(.NSRC(NSRC)) u_core (
    .raw_i      (raw_q),
    .enable_i   (enable_q),
    .route_i    (route_q),
    .wake_sel_i (wake_sel_q),
    .pend_nrm_o (pend_nrm),
    .pend_fst_o (pend_fst),
    .irq_o      (irq_o),
    .fiq_o      (fiq_o),
    .wake_o     (wake_o)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC        = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NSRC-1:0]   req_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [NSRC-1:0]   wdata_i,
  input logic [NSRC-1:0]   rdata_o,
  input logic              irq_o,
  input logic              fiq_o,
  input logic              wake_o,
  input logic [NSRC-1:0]   raw_q,
  input logic [NSRC-1:0]   enable_q,
  input logic [NSRC-1:0]   route_q,
  input logic              wake_sel_q
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_clear_r1: assert (enable_q == '0 && route_q == '0 && !wake_sel_q);
    end
  end

  generate
    if (SYNC_STAGES == 2) begin : g_lat
      p_sync_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q >= 2'd2) |-> (raw_q == $past(req_i, 2)));
    end
  endgenerate

  p_enable_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_ENABLE) |=> (enable_q == $past(wdata_i)));

  p_route_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_ROUTE) |=> (route_q == $past(wdata_i)));

  p_disabled_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_q == '0) |-> (!irq_o && !fiq_o));

  p_all_fast_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_q == '1) |-> !irq_o);

  p_raw_wake_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wake_sel_q && raw_q != '0) |-> wake_o);

  p_ctrl_narrow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFS_CTRL) |-> (rdata_o[NSRC-1:1] == '0));

  p_stray_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i != OFS_ENABLE && addr_i != OFS_ROUTE && addr_i != OFS_CTRL)
      |=> ($stable(enable_q) && $stable(route_q) && $stable(wake_sel_q)));
endmodule

bind irqc_top irqc_checker #(.NSRC(NSRC), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .addr_i     (addr_i),
  .we_i       (we_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .irq_o      (irq_o),
  .fiq_o      (fiq_o),
  .wake_o     (wake_o),
  .raw_q      (raw_q),
  .enable_q   (enable_q),
  .route_q    (route_q),
  .wake_sel_q (wake_sel_q)
);

// File: tb/irqc_top_test.sv
module irqc_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] req = '0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq, wake;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;
  bit in_reset_phase = 1;

  always #10 clk = ~clk;

  irqc_top uut (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .addr_i (addr),
    .we_i (we), .wdata_i (wdata), .rdata_o (rdata),
    .irq_o (irq), .fiq_o (fiq), .wake_o (wake)
  );

  // behavioural reference
  logic [31:0] hist[$] = '{32'h0, 32'h0};
  logic [31:0] m_en = '0, m_rt = '0;
  bit          m_ctl = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{32'h0, 32'h0};
      m_en = '0; m_rt = '0; m_ctl = 0;
    end else begin
      hist.push_back(req);
      void'(hist.pop_front());
      if (we) begin
        if (addr == 8'h04) m_en = wdata;
        else if (addr == 8'h08) m_rt = wdata;
        else if (addr == 8'h0C) m_ctl = wdata[0];
      end
    end
  end

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    logic [31:0] raw = hist[0];
    case (a)
      8'h00: return raw & m_en & ~m_rt;
      8'h04: return m_en;
      8'h08: return m_rt;
      8'h0C: return {31'b0, m_ctl};
      8'h10: return raw & m_en & m_rt;
      8'h20: return raw;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h00: return "R5";
      8'h04: return "R3";
      8'h08: return "R4";
      8'h0C: return "R8";
      8'h10: return "R6";
      8'h20: return "R2";
      default: return "R9";
    endcase
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      logic [31:0] raw, er;
      logic ei, ef, ew;
      raw = hist[0];
      er = exp_read(addr);
      ei = |(raw & m_en & ~m_rt);
      ef = |(raw & m_en & m_rt);
      ew = m_ctl ? |(raw & m_en) : |raw;
      n_vec++;
      if (rdata !== er || irq !== ei || fiq !== ef || wake !== ew) begin
        n_bad++;
        if (in_reset_phase)
          $display("FAIL R1 addr=%h rdata got %h exp %h irq %b/%b fiq %b/%b wake %b/%b",
                   addr, rdata, er, irq, ei, fiq, ef, wake, ew);
        else if (rdata !== er)
          $display("FAIL %s addr=%h rdata got %h exp %h", tag_of(addr), addr, rdata, er);
        if (!in_reset_phase && irq !== ei) $display("FAIL R5 irq_o got %b exp %b", irq, ei);
        if (!in_reset_phase && fiq !== ef) $display("FAIL R6 fiq_o got %b exp %b", fiq, ef);
        if (!in_reset_phase && wake !== ew) $display("FAIL R7 wake_o got %b exp %b", wake, ew);
      end
    end
  end

  task automatic step(input logic [7:0] a, input bit w, input logic [31:0] d);
    @(negedge clk);
    #1;
    addr = a; we = w; wdata = d;
  endtask

  task automatic rd(input logic [7:0] a, input int n);
    for (int i = 0; i < n; i++) step(a, 0, '0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  logic [7:0] pick[8] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h20, 8'h14, 8'h3C};

  initial begin
    // R1: reset state with requests held off
    rd(8'h04, 1); rd(8'h08, 1); rd(8'h0C, 1);
    step(8'h04, 0, '0);
    rst_n = 1'b1;
    rd(8'h08, 1); rd(8'h0C, 1);
    in_reset_phase = 0;
    // R2: two-edge latency of raw status
    req = 32'h8000_F00F;
    rd(8'h20, 4);
    // R7: control clear, nothing enabled, wake follows raw
    rd(8'h00, 1);
    // R3 / R5: enable all, all routed normal
    step(8'h04, 1, 32'hFFFF_FFFF);
    rd(8'h00, 2); rd(8'h04, 1);
    // R4 / R6: route upper nibble of low half and top bit to fast
    step(8'h08, 1, 32'h8000_F000);
    rd(8'h10, 2); rd(8'h00, 1); rd(8'h08, 1);
    // R8: control keeps only bit 0
    step(8'h0C, 1, 32'hFFFF_FFFF);
    rd(8'h0C, 1);
    // R7: wake with nothing enabled under control set
    step(8'h04, 1, 32'h0);
    rd(8'h20, 2);
    step(8'h0C, 1, 32'h0);
    rd(8'h0C, 2);
    // R9: writes to status and unmapped offsets
    step(8'h04, 1, 32'h0000_00FF);
    step(8'h00, 1, 32'hFFFF_FFFF);
    step(8'h10, 1, 32'hFFFF_FFFF);
    step(8'h20, 1, 32'hFFFF_FFFF);
    step(8'h14, 1, 32'hFFFF_FFFF);
    step(8'h3C, 1, 32'hFFFF_FFFF);
    rd(8'h04, 1); rd(8'h08, 1); rd(8'h0C, 1); rd(8'h3C, 1); rd(8'h14, 1);
    // R10: clear only sources 0..11
    step(8'h08, 1, 32'h0);
    step(8'h04, 1, 32'hFFFF_FFFF);
    req = 32'hFFFF_FFFF;
    rd(8'h00, 3);
    step(8'h04, 1, 32'hFFFF_F000);
    rd(8'h00, 2); rd(8'h04, 1);
    req = 32'h0000_0FFF;
    rd(8'h00, 3);
    // R2: status drops with the request, no acknowledge
    req = 32'h0;
    rd(8'h20, 3);
    // random traffic across R2..R9
    for (int i = 0; i < 2000; i++) begin
      if ($urandom_range(0, 3) == 0) req = $urandom();
      step(pick[$urandom_range(0, 7)], ($urandom_range(0, 2) == 0), $urandom());
    end
    rd(8'h20, 2);
    finish_run();
  end
endmodule